// File: doc/BRIEF.md
# Streaming Hue Color Classifier

This block sits at the front of a sign-detection pixel pipeline. It takes one RGB pixel per clock, together with a valid strobe and frame-start and line-end markers. For each pixel it produces a single bit that says whether the pixel has the selected color of interest. Hue is measured on a wheel of 384 units rather than 360 degrees, with 64 units per sixth of the circle. The wheel is turned by 64 units so that true red sits at 64. As a result, no part of the red range wraps past zero and no modulo is needed. Saturation and intensity are never divided out. They are compared by cross-multiplication against programmable limits, and those comparisons feed the yellow and white tests.

The hue quotient comes from a restoring divider that runs one bit per pipeline stage and is built inside the block. Every sideband bit travels next to the divider so that it stays aligned with its own pixel. The color select, the hue band thresholds and the saturation and intensity limits are plain inputs. They are expected to hold steady while pixels of interest are in flight. A degree threshold `d` converts to wheel units as `d*64/60 + 64`.

Top module: `hue_color_classifier`

## Requirements
- R1: `out_valid`, `out_sof` and `out_eol` repeat `in_valid`, `in_sof` and `in_eol` exactly 19 clock cycles later. A pixel driven between two rising edges shows its result after the 19th following edge. Back-to-back pixels come out back to back, with no gaps.
- R2: While `rst_n` is low, all four outputs are 0.
- R3: The hue is computed on the 384-unit wheel. The maximum channel picks the sector: red wins ties with green and blue, and green wins ties with blue. The numerator is G−B when red is the maximum, B−R when green is the maximum and R−G when blue is the maximum. The hue is the sector base (64 for red, 192 for green, 320 for blue) plus 64·numerator/(max−min), truncated toward zero. The result lies in 0..383.
- R4: A pixel with R=G=B has hue 0.
- R5: With `sel`=0 (red), the flag is set when hue ≤ `red_lo` or hue ≥ `red_hi`.
- R6: With `sel`=1 (blue), the flag is set when `blu_lo` ≤ hue ≤ `blu_hi`.
- R7: With `sel`=2 (yellow), the flag is set when `yel_lo` ≤ hue ≤ `yel_hi` and 256·(S−3·min) > `yel_sat`·S, where S=R+G+B.
- R8: With `sel`=3 (white), hue plays no part. The flag is set when 256·(S−3·min) < `wht_sat`·S and S > 3·`wht_int`.
- R9: `out_flag` is 0 in every cycle in which `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| sel | input | 2 | Color tested: 0 red, 1 blue, 2 yellow, 3 white |
| red_lo | input | 9 | Red lower hue bound (inclusive, at or below) |
| red_hi | input | 9 | Red upper hue bound (inclusive, at or above) |
| blu_lo | input | 9 | Blue band low edge |
| blu_hi | input | 9 | Blue band high edge |
| yel_lo | input | 9 | Yellow band low edge |
| yel_hi | input | 9 | Yellow band high edge |
| yel_sat | input | 8 | Yellow saturation floor, in 1/256 steps |
| wht_sat | input | 8 | White saturation ceiling, in 1/256 steps |
| wht_int | input | 8 | White intensity floor |
| out_valid | output | 1 | Delayed pixel valid |
| out_sof | output | 1 | Delayed frame start |
| out_eol | output | 1 | Delayed line end |
| out_flag | output | 1 | Pixel has the selected color |

## Verification
Some properties are checked on every cycle after the pipeline has filled. These are the 19-cycle alignment of valid and both markers, the rule that a flag never appears without valid, the red verdict on any gray pixel and the rejection of black as white. Exact hue values, the tie-breaking between sectors and truncation toward zero can only be shown by the bench, through its one-value blue band that pins each directed pixel's hue. The same holds for the inclusive threshold edges and the cross-multiplied saturation and intensity tests, which the bench covers under random traffic.

// File: rtl/hue_color_classifier.sv
module hue_color_classifier #(
  parameter int PIX_W = 8,
  parameter int HUE_W = 9
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_r,
  input  logic [PIX_W-1:0] in_g,
  input  logic [PIX_W-1:0] in_b,
  input  logic [1:0]       sel,
  input  logic [HUE_W-1:0] red_lo,
  input  logic [HUE_W-1:0] red_hi,
  input  logic [HUE_W-1:0] blu_lo,
  input  logic [HUE_W-1:0] blu_hi,
  input  logic [HUE_W-1:0] yel_lo,
  input  logic [HUE_W-1:0] yel_hi,
  input  logic [PIX_W-1:0] yel_sat,
  input  logic [PIX_W-1:0] wht_sat,
  input  logic [PIX_W-1:0] wht_int,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic             out_flag
);
  localparam int NS    = PIX_W + 8;
  localparam int SUM_W = PIX_W + 2;
  localparam int PRD_W = SUM_W + PIX_W;
  localparam int SB_W  = 9;
  localparam int Q_W   = 7;
  localparam int SEG   = 64;

  logic             r_top, g_top, neg, flat, yel_ok, wht_ok;
  logic [1:0]       sec;
  logic [PIX_W-1:0] mx, mn, pa, pb, mag;
  logic [SUM_W-1:0] sum;
  logic [PRD_W-1:0] chroma;

  assign r_top  = (in_r >= in_g) && (in_r >= in_b);
  assign g_top  = !r_top && (in_g >= in_b);
  assign sec    = r_top ? 2'd0 : (g_top ? 2'd1 : 2'd2);
  assign mx     = r_top ? in_r : (g_top ? in_g : in_b);
  assign mn     = (in_r <= in_g && in_r <= in_b) ? in_r : ((in_g <= in_b) ? in_g : in_b);
  assign pa     = r_top ? in_g : (g_top ? in_b : in_r);
  assign pb     = r_top ? in_b : (g_top ? in_r : in_g);
  assign neg    = pa < pb;
  assign flat   = mx == mn;
  assign mag    = neg ? pb - pa : pa - pb;
  assign sum    = SUM_W'(in_r) + SUM_W'(in_g) + SUM_W'(in_b);
  assign chroma = PRD_W'(sum - SUM_W'(3 * mn)) << PIX_W;
  assign yel_ok = chroma > PRD_W'(yel_sat) * PRD_W'(sum);
  assign wht_ok = (chroma < PRD_W'(wht_sat) * PRD_W'(sum)) && (sum > SUM_W'(3 * wht_int));

  logic [SB_W-1:0]  s1_sb;
  logic [PIX_W-1:0] s1_mag, s1_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sb  <= '0;
      s1_mag <= '0;
      s1_den <= PIX_W'(1);
    end else begin
      s1_sb  <= {in_valid, in_sof, in_eol, sec, neg, flat, yel_ok, wht_ok};
      s1_mag <= flat ? '0 : mag;
      s1_den <= flat ? PIX_W'(1) : mx - mn;
    end
  end

  logic [PIX_W-1:0] st_rem [NS];
  logic [NS-1:0]    st_dvd [NS];
  logic [NS-1:0]    st_quo [NS];
  logic [PIX_W-1:0] st_den [NS];
  logic [SB_W-1:0]  st_sb  [NS];

  for (genvar k = 0; k < NS; k++) begin : g_div
    logic [PIX_W-1:0] rin, dn;
    logic [NS-1:0]    din;
    logic [SB_W-1:0]  sin;
    logic [PIX_W:0]   trial, diff;
    logic             fits;
    if (k == 0) begin : g_head
      assign rin = '0;
      assign din = {2'b00, s1_mag, 6'b000000};
      assign dn  = s1_den;
      assign sin = s1_sb;
    end else begin : g_body
      assign rin = st_rem[k-1];
      assign din = st_dvd[k-1];
      assign dn  = st_den[k-1];
      assign sin = st_sb[k-1];
    end
    assign trial = {rin, din[NS-1]};
    assign diff  = trial - {1'b0, dn};
    assign fits  = !diff[PIX_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_rem[k] <= '0;
        st_dvd[k] <= '0;
        st_den[k] <= PIX_W'(1);
        st_sb[k]  <= '0;
      end else begin
        st_rem[k] <= fits ? diff[PIX_W-1:0] : trial[PIX_W-1:0];
        st_dvd[k] <= din << 1;
        st_den[k] <= dn;
        st_sb[k]  <= sin;
      end
    end
    if (k == 0) begin : g_qhead
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_quo[k] <= '0;
        else        st_quo[k] <= {{(NS-1){1'b0}}, fits};
    end else begin : g_qbody
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st_quo[k] <= '0;
        else        st_quo[k] <= {st_quo[k-1][NS-2:0], fits};
    end
  end

  logic [SB_W-1:0]  tl_sb;
  logic [Q_W-1:0]   q;
  logic [HUE_W-1:0] base, hue_nx, hue_r;
  logic             f_v, f_sof, f_eol, f_yok, f_wok, match;

  assign tl_sb  = st_sb[NS-1];
  assign q      = st_quo[NS-1][Q_W-1:0];
  assign base   = (tl_sb[5:4] == 2'd0) ? HUE_W'(SEG) :
                  (tl_sb[5:4] == 2'd1) ? HUE_W'(3*SEG) : HUE_W'(5*SEG);
  assign hue_nx = tl_sb[2] ? '0 : (tl_sb[3] ? base - HUE_W'(q) : base + HUE_W'(q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hue_r <= '0;
      {f_v, f_sof, f_eol, f_yok, f_wok} <= '0;
    end else begin
      hue_r <= hue_nx;
      {f_v, f_sof, f_eol, f_yok, f_wok} <= {tl_sb[8:6], tl_sb[1:0]};
    end
  end

  always_comb begin
    case (sel)
      2'd0:    match = (hue_r <= red_lo) || (hue_r >= red_hi);
      2'd1:    match = (hue_r >= blu_lo) && (hue_r <= blu_hi);
      2'd2:    match = (hue_r >= yel_lo) && (hue_r <= yel_hi) && f_yok;
      default: match = f_wok;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {out_valid, out_sof, out_eol, out_flag} <= '0;
    end else begin
      {out_valid, out_sof, out_eol} <= {f_v, f_sof, f_eol};
      out_flag <= f_v && match;
    end
  end
endmodule

// File: rtl/hue_color_classifier_chk.sv
module hue_color_classifier_chk #(
  parameter int PIX_W = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eol,
  input logic [PIX_W-1:0] in_r,
  input logic [PIX_W-1:0] in_g,
  input logic [PIX_W-1:0] in_b,
  input logic [1:0]       sel,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eol,
  input logic             out_flag
);
  localparam int LAT = 19;
  logic [4:0] since_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 5'(LAT)) since_rst <= since_rst + 5'd1;

  AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag |-> out_valid); // R9
  AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 5'(LAT)) |-> (out_valid == $past(in_valid, 19))); // R1
  AST_SIDEBAND_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 5'(LAT)) |-> ({out_sof, out_eol} == $past({in_sof, in_eol}, 19))); // R1
  AST_GRAY_IS_RED: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 5'(LAT)) && (sel == 2'd0) &&
     $past(in_valid && (in_r == in_g) && (in_g == in_b), 19)) |-> out_flag); // R4
  AST_BLACK_NOT_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 5'(LAT)) && (sel == 2'd3) &&
     $past(in_valid && (in_r == 0) && (in_g == 0) && (in_b == 0), 19)) |-> !out_flag); // R8
endmodule

bind hue_color_classifier hue_color_classifier_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
  .in_r(in_r), .in_g(in_g), .in_b(in_b), .sel(sel),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_flag(out_flag));

// File: tb/sim_hue_color_classifier.sv
module sim_hue_color_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eol = 0;
  logic [7:0] in_r = 0, in_g = 0, in_b = 0;
  logic [1:0] sel = 0;
  logic [8:0] red_lo = 0, red_hi = 0, blu_lo = 0, blu_hi = 0, yel_lo = 0, yel_hi = 0;
  logic [7:0] yel_sat = 0, wht_sat = 0, wht_int = 0;
  logic out_valid, out_sof, out_eol, out_flag;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  bit ev [32], es [32], ee [32], ef [32];
  string et [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  hue_color_classifier u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .sel(sel),
    .red_lo(red_lo), .red_hi(red_hi), .blu_lo(blu_lo), .blu_hi(blu_hi),
    .yel_lo(yel_lo), .yel_hi(yel_hi), .yel_sat(yel_sat), .wht_sat(wht_sat), .wht_int(wht_int),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_flag(out_flag));

  function automatic int min3(int r, int g, int b);
    int m = r;
    if (g < m) m = g;
    if (b < m) m = b;
    return m;
  endfunction

  function automatic int exp_hue(int r, int g, int b);
    int top, num, base, span;
    if (r == g && g == b) return 0;
    if (r >= g && r >= b)  begin top = r; num = g - b; base = 64;  end
    else if (g >= b)       begin top = g; num = b - r; base = 192; end
    else                   begin top = b; num = r - g; base = 320; end
    span = top - min3(r, g, b);
    if (num < 0) return base - ((-num) * 64) / span;
    return base + (num * 64) / span;
  endfunction

  function automatic bit exp_flag(int r, int g, int b);
    int h = exp_hue(r, g, b);
    int s = r + g + b;
    int c = 256 * (s - 3 * min3(r, g, b));
    case (sel)
      2'd0: return (h <= int'(red_lo)) || (h >= int'(red_hi));
      2'd1: return (h >= int'(blu_lo)) && (h <= int'(blu_hi));
      2'd2: return (h >= int'(yel_lo)) && (h <= int'(yel_hi)) && (c > int'(yel_sat) * s);
      default: return (c < int'(wht_sat) * s) && (s > 3 * int'(wht_int));
    endcase
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, bit sf, bit el, int r, int g, int b, string tag);
    int o;
    @(negedge clk);
    cyc++;
    o = (cyc - LAT + 64) % 32;
    chk(out_valid, ev[o], "R1 valid delay");
    chk(out_sof, es[o], "R1 frame-start delay");
    chk(out_eol, ee[o], "R1 line-end delay");
    chk(out_flag, ef[o], et[o]);
    if (!out_valid && out_flag) begin
      nchk++; nfail++;
      $display("FAIL R9: actual flag 1 expected 0 without valid (cycle %0d)", cyc);
    end
    in_valid = v; in_sof = sf; in_eol = el;
    in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    o = cyc % 32;
    ev[o] = v; es[o] = sf; ee[o] = el;
    ef[o] = v && exp_flag(r, g, b);
    et[o] = v ? tag : "R9 idle flag";
  endtask

  task automatic flush();
    repeat (LAT + 1) step(0, 0, 0, 0, 0, 0, "R9 idle");
  endtask

  task automatic rand_run(int n, int kind, string tag);
    for (int i = 0; i < n; i++) begin
      int r = $urandom_range(0, 255), g = $urandom_range(0, 255), b = $urandom_range(0, 255);
      bit v = ($urandom_range(0, 7) != 0);
      if (kind == 1) begin r = $urandom_range(150, 255); g = $urandom_range(60, 255); b = $urandom_range(0, 80); end
      if (kind == 2) begin
        int base = $urandom_range(0, 255);
        r = (base + $urandom_range(0, 20)) % 256;
        g = (base + $urandom_range(0, 20)) % 256;
        b = (base + $urandom_range(0, 20)) % 256;
      end
      if ($urandom_range(0, 9) == 0) begin g = r; b = r; end
      step(v, v && (i == 0), v && (i % 37 == 36), r, g, b, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int dr [12] = '{255, 255, 0,   0,   0,   255, 255, 50, 0, 255, 10, 0};
    int dg [12] = '{0,   255, 255, 255, 0,   0,   0,   50, 0, 255, 0,  10};
    int db [12] = '{0,   0,   0,   255, 255, 255, 1,   50, 0, 255, 255, 255};
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk(out_valid, 0, "R2 reset valid");
    chk(out_sof, 0, "R2 reset sof");
    chk(out_eol, 0, "R2 reset eol");
    chk(out_flag, 0, "R2 reset flag");
    rst_n = 1'b1;

    sel = 2'd1;
    for (int i = 0; i < 12; i++) begin
      for (int d = 0; d < 2; d++) begin
        int h = exp_hue(dr[i], dg[i], db[i]);
        blu_lo = 9'(h + d); blu_hi = 9'(h + d);
        step(1, 1, 1, dr[i], dg[i], db[i], (dr[i] == dg[i] && dg[i] == db[i]) ? "R4 gray hue" : "R3 exact hue");
        flush();
      end
    end

    sel = 2'd0; red_lo = 9'd74; red_hi = 9'd360;
    rand_run(300, 0, "R5 red random");
    step(1, 0, 0, 90, 90, 90, "R4 gray as red");
    flush();
    red_lo = 9'd64; red_hi = 9'd320;
    for (int i = 0; i < 12; i++) step(1, 0, i == 11, dr[i], dg[i], db[i], "R5 red edge");
    flush();

    sel = 2'd1; blu_lo = 9'd266; blu_hi = 9'd352;
    rand_run(300, 0, "R6 blue random");
    flush();

    sel = 2'd2; yel_lo = 9'd85; yel_hi = 9'd128; yel_sat = 8'd90;
    rand_run(300, 1, "R7 yellow random");
    flush();

    sel = 2'd3; wht_sat = 8'd40; wht_int = 8'd150;
    rand_run(300, 2, "R8 white random");
    step(1, 0, 0, 0, 0, 0, "R8 black");
    step(1, 0, 0, 255, 255, 255, "R8 full white");
    flush();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule